// File: doc/BRIEF.md
# Bus-mapped GPIO register bank

This block is a 32-bit general-purpose I/O port that a simple single-word bus can read and write. It holds the software-visible registers of the port: the sampled input, the software output value, the output enables, the interrupt enables, the trigger polarities, the auxiliary-source select, a control word and the interrupt status. A separate detection block consumes the interrupt-related registers. This block only stores them, reads them back and raises the request line while the status is non-zero.

On each cycle where `tick` is high, the port computes a new pad drive value. For each bit, the auxiliary-select register chooses between the software output value and the matching bit of the auxiliary input bus. Bits that are not output-enabled are forced to zero. In the same cycle the port latches the pad inputs, with output-enabled bits masked to zero. The enables appear directly on `pad_oe`. A one-cycle `out_changed` strobe marks every tick on which the driven value changed.

Top module: `gpio_regbank`

## Requirements
- R1: After reset every register, `pad_out`, `pad_oe`, `out_changed`, `irq` and `rsp_valid` are zero.
- R2: Word offsets are 0x00 input, 0x04 output, 0x08 output-enable, 0x0C interrupt-enable, 0x10 trigger-polarity, 0x14 aux-select, 0x18 control and 0x1C interrupt-status. Every register except the input register reads back the last value written to it.
- R3: A write to offset 0x00 has no effect on the value that offset later reads back.
- R4: A read of offset 0x00 returns the sampled input ORed with the output register.
- R5: On a tick, `pad_out` becomes ((OUT & ~AUX) | (aux_in & AUX)) & OE. `pad_oe` always equals the output-enable register.
- R6: On a tick, the sampled input becomes `pad_in & ~OE`. Without a tick it holds its value.
- R7: Each request is answered by `rsp_valid` high for exactly one cycle, two clock edges after the edge that accepted it. Write responses carry zero data.
- R8: A read of an offset that is above 0x1C or not word-aligned returns zero. A write to such an offset changes no register.
- R9: `out_changed` is high for exactly the cycle after a tick that changed `pad_out`, and is low otherwise.
- R10: `irq` is high exactly while the interrupt-status register is non-zero. Writing zero to that register drops `irq` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, two edges after the request |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| tick | input | 1 | Sampling tick enable |
| pad_in | input | 32 | Pad input levels |
| aux_in | input | 32 | Auxiliary output source |
| pad_out | output | 32 | Driven pad value |
| pad_oe | output | 32 | Per-bit output enables |
| out_changed | output | 1 | One-cycle strobe when the driven value changed |
| irq | output | 1 | Interrupt request |

## Verification
The bench tries the output merge with three patterns:
- A split pattern with mixed select bits and half the enables set. It shows whether the select picks per bit and whether masking follows the merge.
- All bits selecting the auxiliary bus with every enable set. It separates the auxiliary path from the software value.
- All enables cleared. This must force zero whatever the sources hold.

Input samples are taken with the pad levels changed only between ticks. This shows that sampling happens on the tick alone and that enabled bits are masked. Repeated ticks with unchanged inputs separate a true change strobe from one that fires on every tick.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int DW      = 32;
  localparam int REG_CNT = 8;
  localparam int IDX_W   = $clog2(REG_CNT);

  typedef enum logic [IDX_W-1:0] {
    IDX_IN    = 3'd0,
    IDX_OUT   = 3'd1,
    IDX_OE    = 3'd2,
    IDX_INTE  = 3'd3,
    IDX_PTRIG = 3'd4,
    IDX_AUX   = 3'd5,
    IDX_CTRL  = 3'd6,
    IDX_INTS  = 3'd7
  } reg_idx_e;

  // per-bit source select, then mask with the enables
  function automatic logic [DW-1:0] drive_calc(logic [DW-1:0] sw_val,
                                               logic [DW-1:0] aux_val,
                                               logic [DW-1:0] sel,
                                               logic [DW-1:0] en);
    return ((sw_val & ~sel) | (aux_val & sel)) & en;
  endfunction

  function automatic logic [DW-1:0] sample_calc(logic [DW-1:0] lvl,
                                                logic [DW-1:0] en);
    return lvl & ~en;
  endfunction
endpackage

// File: rtl/gpio_bus_pipe.sv
module gpio_bus_pipe
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [DW-1:0]     rd_word,
  output logic [IDX_W-1:0]  sel_idx,
  output logic              wr_en,
  output logic [DW-1:0]     wr_data,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata
);
  localparam int LSB = 2;
  localparam int TOP = LSB + IDX_W;

  logic          mapped;
  logic          s1_v;
  logic [DW-1:0] s1_d;

  generate
    if (ADDR_W > TOP) begin : g_hi
      assign mapped = (req_addr[LSB-1:0] == '0) && (req_addr[ADDR_W-1:TOP] == '0);
    end else begin : g_nohi
      assign mapped = (req_addr[LSB-1:0] == '0);
    end
  endgenerate

  assign sel_idx = req_addr[TOP-1:LSB];
  assign wr_en   = req_valid && req_we && mapped;
  assign wr_data = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s1_d      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      s1_v      <= req_valid;
      s1_d      <= (req_valid && !req_we && mapped) ? rd_word : '0;
      rsp_valid <= s1_v;
      rsp_rdata <= s1_v ? s1_d : '0;
    end
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [DW-1:0]    samp_in,
  output logic [DW-1:0]    rd_word,
  output logic [DW-1:0]    out_reg,
  output logic [DW-1:0]    oe_reg,
  output logic [DW-1:0]    aux_reg,
  output logic [DW-1:0]    ints_reg
);
  logic [DW-1:0] regs [REG_CNT];

  assign regs[0] = '0;  // input slot is not stored here

  generate
    for (genvar g = 1; g < REG_CNT; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)
          regs[g] <= '0;
        else if (wr_en && sel_idx == IDX_W'(g))
          regs[g] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    if (sel_idx == IDX_IN)
      rd_word = samp_in | regs[IDX_OUT];
    else
      rd_word = regs[sel_idx];
  end

  assign out_reg  = regs[IDX_OUT];
  assign oe_reg   = regs[IDX_OE];
  assign aux_reg  = regs[IDX_AUX];
  assign ints_reg = regs[IDX_INTS];
endmodule

// File: rtl/gpio_pad_stage.sv
module gpio_pad_stage
  import gpio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] pad_in,
  input  logic [DW-1:0] aux_in,
  input  logic [DW-1:0] out_reg,
  input  logic [DW-1:0] oe_reg,
  input  logic [DW-1:0] aux_reg,
  output logic [DW-1:0] drive_q,
  output logic [DW-1:0] samp_q,
  output logic          chg_q
);
  logic [DW-1:0] drive_nx;

  assign drive_nx = drive_calc(out_reg, aux_in, aux_reg, oe_reg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive_q <= '0;
      samp_q  <= '0;
      chg_q   <= 1'b0;
    end else begin
      chg_q <= tick && (drive_nx != drive_q);
      if (tick) begin
        drive_q <= drive_nx;
        samp_q  <= sample_calc(pad_in, oe_reg);
      end
    end
  end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              tick,
  input  logic [31:0]       pad_in,
  input  logic [31:0]       aux_in,
  output logic [31:0]       pad_out,
  output logic [31:0]       pad_oe,
  output logic              out_changed,
  output logic              irq
);
  logic [IDX_W-1:0] sel_idx;
  logic             wr_en;
  logic [DW-1:0]    wr_data, rd_word, samp_in;
  logic [DW-1:0]    out_reg, oe_reg, aux_reg, ints_reg;

  // named events for the checker
  logic ev_wr_in, ev_ints_clear;
  assign ev_wr_in      = wr_en && (sel_idx == IDX_IN);
  assign ev_ints_clear = wr_en && (sel_idx == IDX_INTS) && (wr_data == '0);

  gpio_bus_pipe #(.ADDR_W(ADDR_W)) bus_i (
    .clk, .rst_n, .req_valid, .req_we, .req_addr, .req_wdata,
    .rd_word, .sel_idx, .wr_en, .wr_data, .rsp_valid, .rsp_rdata
  );

  gpio_regfile rf_i (
    .clk, .rst_n, .wr_en, .sel_idx, .wr_data, .samp_in,
    .rd_word, .out_reg, .oe_reg, .aux_reg, .ints_reg
  );

  gpio_pad_stage pad_i (
    .clk, .rst_n, .tick, .pad_in, .aux_in, .out_reg, .oe_reg, .aux_reg,
    .drive_q(pad_out), .samp_q(samp_in), .chg_q(out_changed)
  );

  assign pad_oe = oe_reg;
  assign irq    = |ints_reg;
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        rsp_valid,
  input logic        tick,
  input logic [31:0] pad_out,
  input logic [31:0] pad_oe,
  input logic        out_changed,
  input logic        irq,
  input logic [31:0] samp_in,
  input logic        ev_wr_in,
  input logic        ev_ints_clear
);
  a_r7_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ##1 rsp_valid);
  a_r7_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid, 2));
  a_r9_strobe_means_change: assert property (@(posedge clk) disable iff (!rst_n)
    out_changed |-> (pad_out != $past(pad_out)));
  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pad_out) && !out_changed);
  a_r5_drive_masked: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((pad_out & ~$past(pad_oe)) == 32'h0));
  a_r6_sample_masked: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((samp_in & $past(pad_oe)) == 32'h0));
  a_r3_in_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_in && !tick) |=> $stable(samp_in));
  a_r10_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ints_clear |=> !irq);
endmodule

bind gpio_regbank gpio_regbank_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .tick(tick), .pad_out(pad_out), .pad_oe(pad_oe), .out_changed(out_changed),
  .irq(irq), .samp_in(samp_in), .ev_wr_in(ev_wr_in), .ev_ints_clear(ev_ints_clear)
);

// File: tb/gpio_regbank_tb_top.sv
`timescale 1ns/1ps
module gpio_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        tick = 1'b0;
  logic [31:0] pad_in = '0, aux_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        out_changed, irq;

  always #2 clk = ~clk;  // 250 MHz

  gpio_regbank #(.ADDR_W(6)) dut_i (.*);

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // model state
  logic [31:0] m_reg [8];
  logic [31:0] m_samp = '0, m_drive = '0;

  // scoreboard
  logic [31:0] q_data [$];
  int          q_cyc [$];
  string       q_tag [$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_data.size() == 0) check("R7 unexpected response", 32'd1, 32'd0);
      else begin
        string t; logic [31:0] d; int c;
        t = q_tag.pop_front(); d = q_data.pop_front(); c = q_cyc.pop_front();
        check({t, " data"}, rsp_rdata, d);
        check("R7 response cycle", cyc, c);
      end
    end
  end

  function automatic logic [31:0] model_read(logic [5:0] a);
    if (a[1:0] != 0 || a[5] != 0) return 32'h0;
    if (a[4:2] == 0) return m_samp | m_reg[1];
    return m_reg[a[4:2]];
  endfunction

  task automatic bus(bit we, logic [5:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    q_tag.push_back(tag);
    q_data.push_back(we ? 32'h0 : model_read(a));
    q_cyc.push_back(cyc + 2);
    @(posedge clk);
    if (we && a[1:0] == 0 && a[5] == 0 && a[4:2] != 0) m_reg[a[4:2]] = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic do_tick(string tag);
    logic [31:0] nd;
    @(negedge clk);
    tick = 1'b1;
    nd = ((m_reg[1] & ~m_reg[5]) | (aux_in & m_reg[5])) & m_reg[2];
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
    check({tag, " R5 pad_out"}, pad_out, nd);
    check({tag, " R9 strobe"}, {31'b0, out_changed}, {31'b0, nd != m_drive});
    m_drive = nd;
    m_samp  = pad_in & ~m_reg[2];
    @(negedge clk);
    check({tag, " R9 strobe one cycle"}, {31'b0, out_changed}, 32'h0);
  endtask

  task automatic drain;
    repeat (4) @(negedge clk);
    check("R7 all responses seen", q_data.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pad_out", pad_out, 0);
    check("R1 pad_oe", pad_oe, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 0);
    check("R1 out_changed", {31'b0, out_changed}, 0);
    for (int i = 0; i < 8; i++) bus(0, 6'(i*4), 0, "R1 reset read");
    drain();

    // R5 split pattern
    pad_in = 32'hCAFE_BABE; aux_in = 32'h1234_5678;
    bus(1, 6'h04, 32'hA5A5_F00F, "R2 write OUT");
    bus(1, 6'h08, 32'hFFFF_0000, "R2 write OE");
    bus(1, 6'h14, 32'h0F0F_00FF, "R2 write AUX");
    @(negedge clk);
    check("R5 pad_oe follows OE", pad_oe, 32'hFFFF_0000);
    do_tick("split");
    do_tick("repeat");  // no change: strobe low
    bus(0, 6'h00, 0, "R4 R6 read IN");
    // R3 write to IN ignored
    bus(1, 6'h00, 32'hFFFF_FFFF, "R3 write IN");
    bus(0, 6'h00, 0, "R3 read IN after write");
    // R6 no sampling without tick
    pad_in = 32'h0000_FFFF;
    repeat (3) @(negedge clk);
    bus(0, 6'h00, 0, "R6 IN held without tick");
    // R2 readback
    bus(1, 6'h0C, 32'h1357_9BDF, "R2 write INTE");
    bus(1, 6'h10, 32'h2468_ACE0, "R2 write PTRIG");
    bus(1, 6'h18, 32'h8000_0003, "R2 write CTRL");
    bus(0, 6'h0C, 0, "R2 read INTE");
    bus(0, 6'h10, 0, "R2 read PTRIG");
    bus(0, 6'h18, 0, "R2 read CTRL");
    bus(0, 6'h14, 0, "R2 read AUX");
    // R8 unmapped / misaligned
    bus(1, 6'h24, 32'hDEAD_BEEF, "R8 write unmapped");
    bus(1, 6'h06, 32'hDEAD_BEEF, "R8 write misaligned");
    bus(0, 6'h24, 0, "R8 read unmapped");
    bus(0, 6'h05, 0, "R8 read misaligned");
    bus(0, 6'h04, 0, "R8 OUT untouched");
    // R10 irq
    bus(1, 6'h1C, 32'h0000_0003, "R10 set INTS");
    check("R10 irq high", {31'b0, irq}, 1);
    bus(0, 6'h1C, 0, "R10 read INTS");
    bus(1, 6'h1C, 32'h0, "R10 clear INTS");
    check("R10 irq low", {31'b0, irq}, 0);
    // R5 all aux, all enabled
    bus(1, 6'h08, 32'hFFFF_FFFF, "R2 write OE all");
    bus(1, 6'h14, 32'hFFFF_FFFF, "R2 write AUX all");
    aux_in = 32'h0F1E_2D3C;
    do_tick("all-aux");
    bus(0, 6'h00, 0, "R6 IN masked all enabled");
    // R5 no enables
    bus(1, 6'h08, 32'h0, "R2 write OE none");
    pad_in = 32'h8421_0001;
    do_tick("no-oe");
    bus(0, 6'h00, 0, "R4 R6 read IN no-oe");
    drain();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule